// File: doc/BRIEF.md
# MI Coherence Line Controller

This block keeps the coherence state of one line of a private cache under a two-state ownership protocol: a line is either owned with write permission (Modified) or absent (Invalid). Every processor read, instruction fetch, store or atomic that misses asks the directory for exclusive ownership. A dirty line that leaves the cache is written back. The line's data is parked in a one-entry side buffer while the writeback is in flight. From that buffer the controller can still serve a forwarded ownership request from another cache, and it can survive a negative acknowledgement from the directory.

Three handshaked input ports feed the controller: processor operations, messages forwarded by the directory and data replies. At most one message is taken per cycle. Data replies win over forwarded messages, and forwarded messages win over processor operations. A message the current state cannot take yet is held with its ready low. Outgoing requests to the directory leave after a fixed issue latency. Data sent to other caches leaves after a longer fixed response latency. Completions and an optional eviction notice go back to the processor one cycle after the triggering message is taken.

Top module: `mi_line_ctrl`

## Requirements
- R1: After reset the line is Invalid. No valid output is raised, both counters read zero and the protocol-error flag is low.
- R2: In Invalid, a processor op 0 (load), 1 (instruction fetch), 2 (store) or 3 (atomic) is accepted. The miss counter increments. An exclusive-get request (`req_kind` 0, data 0) appears on the request channel exactly ISSUE_LAT cycles after the accepting cycle.
- R3: A data reply taken while a fetch is outstanding raises `done_valid` in the next cycle with the reply data. `done_write` is 1 if the fetch came from a store or atomic and 0 if it came from a load or fetch. The line becomes Modified.
- R4: In Modified, ops 0 to 3 complete in the next cycle as hits. The line data is returned, `done_write` is 1 only for ops 2 and 3, the hit counter increments and no request is sent.
- R5: A forwarded exclusive-get (type 0) in Modified sends the line data to the requester identified in `fwd_src`, RESP_LAT cycles after acceptance. It pulses the eviction notice when SEND_EVICT is set and returns the line to Invalid.
- R6: A replacement (op 4) or a forwarded invalidate (type 1) in Modified parks the data in the side buffer. It sends a writeback request (`req_kind` 1) carrying the data after ISSUE_LAT cycles and pulses the eviction notice. The controller then waits for the writeback outcome.
- R7: While a writeback is pending, the following apply:
  - An ack (type 2) returns the line to Invalid.
  - An invalidate is consumed with no effect.
  - An exclusive-get is answered from the side buffer.
  - A nack (type 3) moves to the nacked-writeback state.
- R8: After a buffer-served exclusive-get, a nack returns the line to Invalid. In the nacked-writeback state, an exclusive-get is answered from the buffer and returns the line to Invalid.
- R9: Processor ops 0 to 4 are held (not ready) in every transient state. Forwarded exclusive-gets and invalidates are held while a fetch is outstanding. In Invalid, a replacement or invalidate is consumed with no effect.
- R10: At most one of the three ready outputs is high in a cycle. A valid data reply takes precedence over a forwarded message, and a forwarded message takes precedence over a processor op.
- R11: A message that is unexpected in the current state is consumed. This covers processor ops 5 to 7. The message sets a sticky protocol-error flag and leaves the line state and data unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor operation present |
| cpu_op | input | 3 | 0 load, 1 fetch, 2 store, 3 atomic, 4 replacement |
| cpu_ready | output | 1 | Processor operation taken this cycle |
| fwd_valid | input | 1 | Forwarded directory message present |
| fwd_type | input | 2 | 0 exclusive-get, 1 invalidate, 2 writeback ack, 3 writeback nack |
| fwd_src | input | ID_W | Requester identity carried by the forwarded message |
| fwd_ready | output | 1 | Forwarded message taken this cycle |
| rsp_valid | input | 1 | Data reply present |
| rsp_data | input | DATA_W | Data reply payload |
| rsp_ready | output | 1 | Data reply taken this cycle |
| req_valid | output | 1 | Request to directory |
| req_kind | output | 1 | 0 exclusive-get, 1 writeback |
| req_data | output | DATA_W | Writeback payload, zero for exclusive-get |
| out_valid | output | 1 | Data sent to another cache |
| out_dest | output | ID_W | Destination requester |
| out_data | output | DATA_W | Line data sent |
| done_valid | output | 1 | Completion toward processor |
| done_write | output | 1 | Completion is for a store or atomic |
| done_data | output | DATA_W | Line data at completion |
| evict_notice | output | 1 | Line left the cache |
| hit_count | output | CNT_W | Hit counter |
| miss_count | output | CNT_W | Miss counter |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The assertions assume that the environment keeps a message stable while its valid is high and ready is low. They also assume that data replies arrive only while a fetch is outstanding, except when an error case is provoked on purpose. The bench drives each message for exactly one edge and checks ready before that edge, so a held message is withdrawn rather than left pending. Replies and nacks are sent only after the matching request has been seen. Error cases are run from a fresh reset, so the sticky flag's rise can be credited to a single message.

// File: rtl/mi_line_pkg.sv
package mi_line_pkg;

  typedef enum logic [2:0] {
    ST_I, ST_IS, ST_IM, ST_M, ST_MI, ST_II, ST_MII
  } line_st_e;

  typedef enum logic [3:0] {
    EV_NONE, EV_RD, EV_WR, EV_REPL, EV_BADOP,
    EV_DATA, EV_GETX, EV_INV, EV_ACK, EV_NACK
  } line_ev_e;

  typedef struct packed {
    logic     take;
    line_st_e nxt;
    logic     err;
    logic     hit;
    logic     miss;
    logic     get;
    logic     put;
    logic     snd_line;
    logic     snd_buf;
    logic     buf_fill;
    logic     buf_free;
    logic     fill;
    logic     done;
    logic     evict;
  } line_act_t;

  function automatic line_ev_e cpu_event(logic [2:0] op);
    case (op)
      3'd0, 3'd1: return EV_RD;
      3'd2, 3'd3: return EV_WR;
      3'd4:       return EV_REPL;
      default:    return EV_BADOP;
    endcase
  endfunction

  function automatic line_ev_e fwd_event(logic [1:0] t);
    case (t)
      2'd0:    return EV_GETX;
      2'd1:    return EV_INV;
      2'd2:    return EV_ACK;
      default: return EV_NACK;
    endcase
  endfunction

  function automatic logic is_write_done(line_st_e s, line_ev_e e);
    return (e == EV_WR) || (s == ST_IM);
  endfunction

  // Complete transition table of the line; take=0 means the message stalls.
  function automatic line_act_t line_step(line_st_e s, line_ev_e e);
    line_act_t a;
    a      = '0;
    a.nxt  = s;
    a.take = (e != EV_NONE);
    if (e != EV_NONE) begin
      case (s)
        ST_I: case (e)
          EV_RD, EV_WR: begin
            a.miss = 1'b1; a.get = 1'b1;
            a.nxt  = (e == EV_RD) ? ST_IS : ST_IM;
          end
          EV_REPL, EV_INV: ;
          default: a.err = 1'b1;
        endcase
        ST_IS, ST_IM: case (e)
          EV_DATA: begin a.fill = 1'b1; a.done = 1'b1; a.nxt = ST_M; end
          EV_RD, EV_WR, EV_REPL, EV_GETX, EV_INV: a.take = 1'b0;
          default: a.err = 1'b1;
        endcase
        ST_M: case (e)
          EV_RD, EV_WR: begin a.hit = 1'b1; a.done = 1'b1; end
          EV_GETX: begin a.snd_line = 1'b1; a.evict = 1'b1; a.nxt = ST_I; end
          EV_REPL, EV_INV: begin
            a.buf_fill = 1'b1; a.put = 1'b1; a.evict = 1'b1; a.nxt = ST_MI;
          end
          default: a.err = 1'b1;
        endcase
        ST_MI: case (e)
          EV_ACK:  begin a.buf_free = 1'b1; a.nxt = ST_I; end
          EV_INV:  ;
          EV_GETX: begin a.snd_buf = 1'b1; a.nxt = ST_II; end
          EV_NACK: a.nxt = ST_MII;
          EV_RD, EV_WR, EV_REPL: a.take = 1'b0;
          default: a.err = 1'b1;
        endcase
        ST_MII: case (e)
          EV_GETX: begin a.snd_buf = 1'b1; a.buf_free = 1'b1; a.nxt = ST_I; end
          EV_RD, EV_WR, EV_REPL: a.take = 1'b0;
          default: a.err = 1'b1;
        endcase
        default: case (e) // ST_II
          EV_NACK: begin a.buf_free = 1'b1; a.nxt = ST_I; end
          EV_RD, EV_WR, EV_REPL: a.take = 1'b0;
          default: a.err = 1'b1;
        endcase
      endcase
    end
    return a;
  endfunction

endpackage

// File: rtl/mi_delay_line.sv
module mi_delay_line #(
  parameter int W   = 8,
  parameter int LAT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < LAT; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[LAT-1];
endmodule

// File: rtl/mi_msg_select.sv
module mi_msg_select
  import mi_line_pkg::*;
(
  input  line_st_e    state,
  input  logic        cpu_valid,
  input  logic [2:0]  cpu_op,
  input  logic        fwd_valid,
  input  logic [1:0]  fwd_type,
  input  logic        rsp_valid,
  output line_ev_e    ev,
  output line_act_t   act,
  output logic        cpu_ready,
  output logic        fwd_ready,
  output logic        rsp_ready
);
  always_comb begin
    if (rsp_valid)      ev = EV_DATA;
    else if (fwd_valid) ev = fwd_event(fwd_type);
    else if (cpu_valid) ev = cpu_event(cpu_op);
    else                ev = EV_NONE;
    act       = line_step(state, ev);
    rsp_ready = rsp_valid && act.take;
    fwd_ready = !rsp_valid && fwd_valid && act.take;
    cpu_ready = !rsp_valid && !fwd_valid && cpu_valid && act.take;
  end
endmodule

// File: rtl/mi_line_ctrl.sv
module mi_line_ctrl
  import mi_line_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ID_W       = 4,
  parameter int CNT_W      = 16,
  parameter int ISSUE_LAT  = 2,
  parameter int RESP_LAT   = 12,
  parameter bit SEND_EVICT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic [2:0]        cpu_op,
  output logic              cpu_ready,
  input  logic              fwd_valid,
  input  logic [1:0]        fwd_type,
  input  logic [ID_W-1:0]   fwd_src,
  output logic              fwd_ready,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              rsp_ready,
  output logic              req_valid,
  output logic              req_kind,
  output logic [DATA_W-1:0] req_data,
  output logic              out_valid,
  output logic [ID_W-1:0]   out_dest,
  output logic [DATA_W-1:0] out_data,
  output logic              done_valid,
  output logic              done_write,
  output logic [DATA_W-1:0] done_data,
  output logic              evict_notice,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic              proto_err
);
  localparam int REQ_W = 2 + DATA_W;
  localparam int OUT_W = 1 + ID_W + DATA_W;

  line_st_e          state;
  line_ev_e          ev;
  line_act_t         act;
  logic [DATA_W-1:0] line_q, buf_q;
  logic              buf_vld;

  // named internal events
  logic ev_fire, ev_req, ev_send;
  logic [REQ_W-1:0] req_in, req_out;
  logic [OUT_W-1:0] out_in, out_out;

  mi_msg_select u_sel (
    .state(state), .cpu_valid(cpu_valid), .cpu_op(cpu_op),
    .fwd_valid(fwd_valid), .fwd_type(fwd_type), .rsp_valid(rsp_valid),
    .ev(ev), .act(act), .cpu_ready(cpu_ready), .fwd_ready(fwd_ready),
    .rsp_ready(rsp_ready)
  );

  assign ev_fire = act.take;
  assign ev_req  = ev_fire && (act.get || act.put);
  assign ev_send = ev_fire && (act.snd_line || act.snd_buf);
  assign req_in  = {ev_req, act.put, act.put ? line_q : {DATA_W{1'b0}}};
  assign out_in  = {ev_send, fwd_src, act.snd_buf ? buf_q : line_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_I;
      line_q       <= '0;
      buf_q        <= '0;
      buf_vld      <= 1'b0;
      hit_count    <= '0;
      miss_count   <= '0;
      proto_err    <= 1'b0;
      done_valid   <= 1'b0;
      done_write   <= 1'b0;
      done_data    <= '0;
      evict_notice <= 1'b0;
    end else begin
      done_valid   <= ev_fire && act.done;
      evict_notice <= ev_fire && act.evict && SEND_EVICT;
      if (ev_fire) begin
        state <= act.nxt;
        if (act.fill)     line_q <= rsp_data;
        if (act.buf_fill) begin buf_q <= line_q; buf_vld <= 1'b1; end
        if (act.buf_free) buf_vld <= 1'b0;
        if (act.hit)      hit_count  <= hit_count + 1'b1;
        if (act.miss)     miss_count <= miss_count + 1'b1;
        if (act.err)      proto_err  <= 1'b1;
        if (act.done) begin
          done_write <= is_write_done(state, ev);
          done_data  <= act.fill ? rsp_data : line_q;
        end
      end
    end
  end

  mi_delay_line #(.W(REQ_W), .LAT(ISSUE_LAT)) u_req_dly (
    .clk(clk), .rst_n(rst_n), .din(req_in), .dout(req_out));
  mi_delay_line #(.W(OUT_W), .LAT(RESP_LAT)) u_out_dly (
    .clk(clk), .rst_n(rst_n), .din(out_in), .dout(out_out));

  assign {req_valid, req_kind, req_data} = req_out;
  assign {out_valid, out_dest, out_data} = out_out;

  AST_SINGLE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_ready, fwd_ready, cpu_ready})); // R10
  AST_RSP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!fwd_ready && !cpu_ready)); // R10
  AST_FILL_TO_M: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && (state == ST_IS || state == ST_IM)) |=> (state == ST_M && done_valid)); // R3
  AST_HIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && state == ST_M && cpu_op <= 3'd3) |=> done_valid); // R4
  AST_BUF_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state inside {ST_MI, ST_II, ST_MII}) |-> buf_vld); // R7
  AST_CPU_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_op <= 3'd4 && !(state inside {ST_I, ST_M})) |-> !cpu_ready); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R11
  AST_ERR_NOMOVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proto_err) |-> (state == $past(state))); // R11
endmodule

// File: tb/tb_mi_line_ctrl.sv
module tb_mi_line_ctrl;
  localparam int DW = 32;
  localparam int IW = 4;
  localparam int CW = 16;
  localparam int IL = 2;
  localparam int RL = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_valid = 1'b0;
  logic [2:0] cpu_op = '0;
  logic fwd_valid = 1'b0;
  logic [1:0] fwd_type = '0;
  logic [IW-1:0] fwd_src = '0;
  logic rsp_valid = 1'b0;
  logic [DW-1:0] rsp_data = '0;
  logic cpu_ready, fwd_ready, rsp_ready, req_valid, req_kind, out_valid;
  logic done_valid, done_write, evict_notice, proto_err;
  logic [DW-1:0] req_data, out_data, done_data;
  logic [IW-1:0] out_dest;
  logic [CW-1:0] hit_count, miss_count;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  mi_line_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_op(cpu_op),
    .cpu_ready(cpu_ready), .fwd_valid(fwd_valid), .fwd_type(fwd_type),
    .fwd_src(fwd_src), .fwd_ready(fwd_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_ready(rsp_ready), .req_valid(req_valid),
    .req_kind(req_kind), .req_data(req_data), .out_valid(out_valid),
    .out_dest(out_dest), .out_data(out_data), .done_valid(done_valid),
    .done_write(done_write), .done_data(done_data),
    .evict_notice(evict_notice), .hit_count(hit_count),
    .miss_count(miss_count), .proto_err(proto_err)
  );

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cpu_valid = 0; fwd_valid = 0; rsp_valid = 0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic cpu_go(logic [2:0] op, bit exp_rdy, string tag);
    cpu_valid = 1'b1; cpu_op = op; #1;
    chk(tag, cpu_ready, exp_rdy);
    step(); cpu_valid = 1'b0;
  endtask

  task automatic fwd_go(logic [1:0] t, logic [IW-1:0] src, bit exp_rdy, string tag);
    fwd_valid = 1'b1; fwd_type = t; fwd_src = src; #1;
    chk(tag, fwd_ready, exp_rdy);
    step(); fwd_valid = 1'b0;
  endtask

  task automatic rsp_go(logic [DW-1:0] d, bit exp_rdy, string tag);
    rsp_valid = 1'b1; rsp_data = d; #1;
    chk(tag, rsp_ready, exp_rdy);
    step(); rsp_valid = 1'b0;
  endtask

  // entered one cycle after acceptance
  task automatic wait_req(bit kind, logic [DW-1:0] d, string tag);
    for (int i = 1; i < IL; i++) begin chk({tag, " early"}, req_valid, 0); step(); end
    chk(tag, req_valid, 1); chk(tag, req_kind, kind); chk(tag, req_data, d);
  endtask

  task automatic wait_out(logic [IW-1:0] dst, logic [DW-1:0] d, string tag);
    for (int i = 1; i < RL; i++) begin chk({tag, " early"}, out_valid, 0); step(); end
    chk(tag, out_valid, 1); chk(tag, out_dest, dst); chk(tag, out_data, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 req", req_valid, 0); chk("R1 out", out_valid, 0);
    chk("R1 done", done_valid, 0); chk("R1 evict", evict_notice, 0);
    chk("R1 hits", hit_count, 0); chk("R1 miss", miss_count, 0);
    chk("R1 err", proto_err, 0);

    // R9 replacement and invalidate in Invalid do nothing
    cpu_go(3'd4, 1, "R9 repl in I");
    fwd_go(2'd1, 0, 1, "R9 inv in I");
    for (int i = 0; i < IL + 1; i++) begin chk("R9 no req", req_valid, 0); step(); end
    chk("R9 miss", miss_count, 0); chk("R9 err", proto_err, 0);

    for (int op = 0; op < 4; op++) begin
      logic [DW-1:0] d;
      d = 32'hC0DE_0000 + DW'(op * 32'h0101);
      cpu_go(3'(op), 1, "R2 miss accept");
      chk("R2 miss count", miss_count, op + 1);
      chk("R2 no done", done_valid, 0);
      wait_req(1'b0, '0, "R2 getx");
      cpu_go(3'd0, 0, "R9 cpu stall fetch");
      fwd_go(2'd0, 3, 0, "R9 getx stall fetch");
      fwd_go(2'd1, 3, 0, "R9 inv stall fetch");
      cpu_go(3'd4, 0, "R9 repl stall fetch");
      rsp_go(d, 1, "R3 reply");
      chk("R3 done", done_valid, 1);
      chk("R3 write", done_write, op >= 2);
      chk("R3 data", done_data, d);
      for (int h = 0; h < 4; h++) begin
        cpu_go(3'(h), 1, "R4 hit");
        chk("R4 done", done_valid, 1);
        chk("R4 write", done_write, h >= 2);
        chk("R4 data", done_data, d);
        chk("R4 count", hit_count, op * 4 + h + 1);
        chk("R4 no req", req_valid, 0);
      end
      case (op)
        0: begin
          fwd_go(2'd0, 5, 1, "R5 getx in M");
          chk("R5 evict", evict_notice, 1);
          wait_out(5, d, "R5 data out");
        end
        1: begin
          cpu_go(3'd4, 1, "R6 repl in M");
          chk("R6 evict", evict_notice, 1);
          wait_req(1'b1, d, "R6 writeback");
          cpu_go(3'd2, 0, "R9 cpu stall wb");
          fwd_go(2'd2, 0, 1, "R7 ack");
        end
        2: begin
          fwd_go(2'd1, 0, 1, "R6 inv in M");
          chk("R6 evict", evict_notice, 1);
          wait_req(1'b1, d, "R6 writeback");
          fwd_go(2'd1, 0, 1, "R7 inv in wb");
          chk("R7 inv no err", proto_err, 0);
          fwd_go(2'd0, 7, 1, "R7 getx in wb");
          wait_out(7, d, "R7 buffer out");
          cpu_go(3'd0, 0, "R9 cpu stall served");
          fwd_go(2'd3, 0, 1, "R8 nack after serve");
        end
        default: begin
          cpu_go(3'd4, 1, "R6 repl in M");
          wait_req(1'b1, d, "R6 writeback");
          fwd_go(2'd3, 0, 1, "R7 nack");
          cpu_go(3'd0, 0, "R9 cpu stall nacked");
          fwd_go(2'd0, 9, 1, "R8 getx nacked");
          wait_out(9, d, "R8 buffer out");
        end
      endcase
      chk("R11 no err in flow", proto_err, 0);
    end
    cpu_go(3'd0, 1, "R8 back to I");
    chk("R8 miss count", miss_count, 5);

    // R10 priority
    do_reset();
    cpu_go(3'd0, 1, "R10 setup miss");
    wait_req(1'b0, '0, "R10 getx");
    step();
    rsp_valid = 1; rsp_data = 32'h1234_5678; fwd_valid = 1; fwd_type = 2'd1; #1;
    chk("R10 rsp wins", rsp_ready, 1); chk("R10 fwd waits", fwd_ready, 0);
    step(); rsp_valid = 0; #1;
    chk("R10 fwd next", fwd_ready, 1);
    step(); fwd_valid = 0;
    chk("R10 evict", evict_notice, 1);
    wait_req(1'b1, 32'h1234_5678, "R10 writeback");
    fwd_valid = 1; fwd_type = 2'd2; cpu_valid = 1; cpu_op = 3'd0; #1;
    chk("R10 fwd over cpu", fwd_ready, 1); chk("R10 cpu waits", cpu_ready, 0);
    step(); fwd_valid = 0; #1;
    chk("R10 cpu after ack", cpu_ready, 1);
    step(); cpu_valid = 0;
    chk("R10 miss", miss_count, 2);

    // R11 errors
    do_reset();
    fwd_go(2'd2, 0, 1, "R11 ack in I");
    chk("R11 err set", proto_err, 1);
    cpu_go(3'd1, 1, "R11 still I");
    chk("R11 miss", miss_count, 1);
    wait_req(1'b0, '0, "R11 getx");
    rsp_go(32'hFACE_0001, 1, "R11 fill");
    do_reset();
    cpu_go(3'd2, 1, "R11 setup");
    step();
    rsp_go(32'hBEEF_0002, 1, "R11 fill2");
    chk("R11 no err yet", proto_err, 0);
    rsp_go(32'hDEAD_0003, 1, "R11 stray reply");
    chk("R11 err stray", proto_err, 1);
    cpu_go(3'd0, 1, "R11 still M");
    chk("R11 line kept", done_data, 32'hBEEF_0002);
    do_reset();
    cpu_go(3'd6, 1, "R11 bad op");
    chk("R11 bad op err", proto_err, 1);
    repeat (3) step();
    chk("R11 sticky", proto_err, 1);
    chk("R11 no req", req_valid, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule